// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small accumulator-based processor. Each cycle it takes an accumulator byte, a second byte, an opcode and a carry-in. The second byte can come from a register, from memory or from an immediate that follows the opcode. It returns a result byte and two destination strobes. The strobes tell the surrounding datapath whether the result goes back to the accumulator or to the register that the increment or decrement named. The datapath then performs the write.

The result and the strobes are combinational. Five status flags (sign, zero, half carry, parity and carry) are kept in a flags register inside the block, which updates on the clock edge where the write-enable is high. Each operation class updates only its own subset of the flags. The other flags keep their stored values. The carry-in comes from a port, so the caller can feed the stored carry flag back into it for add-with-carry, subtract-with-borrow and the rotates through carry.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (add with carry-in) return the low 8 bits of acc + operand (+ carry_i for opcode 1). They assert the accumulator strobe and set carry (flags_o bit 0) when the true sum exceeds 255.
- R2: Opcode 2 (subtract) and opcode 3 (subtract with borrow-in carry_i) return the low 8 bits of acc − operand (− carry_i for opcode 3). They assert the accumulator strobe and set carry when the true difference is negative.
- R3: Half carry (flags_o bit 2) is set by an addition when the low nibbles plus carry-in exceed 15. It is set by a subtraction, compare or decrement when the low-nibble difference, minus any borrow-in, is negative.
- R4: For every operation that updates the result flags, zero (flags_o bit 3) is set exactly when the result is 0, and sign (flags_o bit 4) equals result bit 7.
- R5: For every operation that updates the result flags, parity (flags_o bit 1) is set when the result holds an even number of 1 bits.
- R6: Opcodes 4 (AND), 5 (XOR) and 6 (OR) return the bitwise function of acc and operand, assert the accumulator strobe, and clear both carry and half carry.
- R7: Opcode 7 (compare) sets all five flags as a subtract does, and asserts neither destination strobe.
- R8: Opcodes 8 (increment) and 9 (decrement) act on the second operand (the target register or memory byte), assert only the register strobe, update sign, zero, half carry and parity, and leave carry unchanged.
- R9: Opcodes 10 to 13 rotate the accumulator: 10 left circular, 11 right circular, 12 left through carry_i, 13 right through carry_i. The bit shifted out goes to carry, the accumulator strobe is asserted, and the other four flags are unchanged.
- R10: After reset flags_o is 0. flags_o changes only on a clock edge where we_i is high, and a cycle with we_i low leaves it unchanged.
- R11: Opcodes 14 and 15 assert no strobe and leave the flags unchanged. At most one destination strobe is high at any time, and flags_o bits 7 to 5 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Commit the computed flags at this clock edge |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand, or the target of increment and decrement |
| carry_i | input | 1 | Carry or borrow input |
| result_o | output | 8 | Combinational result |
| acc_wr_o | output | 1 | Result is to be written to the accumulator |
| reg_wr_o | output | 1 | Result is to be written to the increment or decrement target |
| flags_o | output | 8 | Registered flags: bit 4 sign, 3 zero, 2 half carry, 1 parity, 0 carry |

## Verification
The result and both strobes are combinational, so they are due in the same cycle as the inputs. The bench drives inputs on the falling edge and samples these outputs one time step later, well before the next rising edge. The flags are due one rising edge later. The bench checks them just after that edge against a model register that it advances only when it drove we_i high. The add and subtract results are swept over all 65536 operand pairs. The flags are checked for every opcode over a grid that includes the nibble and sign boundary bytes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_AND = 4'd4,  OP_XOR = 4'd5,  OP_OR  = 4'd6,  OP_CMP = 4'd7,
    OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_RLC = 4'd10, OP_RRC = 4'd11,
    OP_RAL = 4'd12, OP_RAR = 4'd13, OP_NP0 = 4'd14, OP_NP1 = 4'd15
  } alu_op_e;

  localparam int FL_CY = 0;
  localparam int FL_P  = 1;
  localparam int FL_AC = 2;
  localparam int FL_Z  = 3;
  localparam int FL_S  = 4;
  localparam int FL_W  = 8;

  typedef struct packed {
    logic szp;
    logic ac;
    logic cy;
  } flag_upd_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o
);
  localparam int NIB_W = DATA_W / 2;
  localparam int HI_W  = DATA_W - NIB_W;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [NIB_W:0]    lo_sum;
  logic [HI_W:0]     hi_sum;

  // subtract as a + ~b + ~borrow; carry out inverts to borrow
  assign b_eff  = sub_i ? ~b_i : b_i;
  assign c_eff  = sub_i ? ~cin_i : cin_i;
  assign lo_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
  assign hi_sum = {1'b0, a_i[DATA_W-1:NIB_W]} + {1'b0, b_eff[DATA_W-1:NIB_W]}
                + {{HI_W{1'b0}}, lo_sum[NIB_W]};
  assign res_o  = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
  assign cy_o   = hi_sum[HI_W] ^ sub_i;
  assign ac_o   = lo_sum[NIB_W] ^ sub_i;
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = 1'b0;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_RLC: begin res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]}; cy_o = a_i[DATA_W-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[DATA_W-1:1]};        cy_o = a_i[0];        end
      OP_RAL: begin res_o = {a_i[DATA_W-2:0], cin_i};         cy_o = a_i[DATA_W-1]; end
      OP_RAR: begin res_o = {cin_i, a_i[DATA_W-1:1]};         cy_o = a_i[0];        end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  flag_upd_t         upd_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              ac_i,
  input  logic              cy_i,
  output logic [FL_W-1:0]   flags_o
);
  logic s_q, z_q, ac_q, p_q, cy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q  <= 1'b0;
      z_q  <= 1'b0;
      ac_q <= 1'b0;
      p_q  <= 1'b0;
      cy_q <= 1'b0;
    end else if (we_i) begin
      if (upd_i.szp) begin
        s_q <= res_i[DATA_W-1];
        z_q <= (res_i == '0);
        p_q <= ~^res_i;
      end
      if (upd_i.ac) ac_q <= ac_i;
      if (upd_i.cy) cy_q <= cy_i;
    end
  end

  always_comb begin
    flags_o        = '0;
    flags_o[FL_S]  = s_q;
    flags_o[FL_Z]  = z_q;
    flags_o[FL_AC] = ac_q;
    flags_o[FL_P]  = p_q;
    flags_o[FL_CY] = cy_q;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_wr_o,
  output logic              reg_wr_o,
  output logic [FL_W-1:0]   flags_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] ar_a, ar_b, ar_res, bo_res;
  logic              ar_sub, ar_cin, ar_cy, ar_ac, bo_cy;
  logic              use_arith, cy_sel, ac_sel;
  flag_upd_t         upd;

  assign op = alu_op_e'(op_i);

  always_comb begin
    ar_a      = acc_i;
    ar_b      = opnd_i;
    ar_sub    = 1'b0;
    ar_cin    = 1'b0;
    use_arith = 1'b1;
    acc_wr_o  = 1'b0;
    reg_wr_o  = 1'b0;
    upd       = '{szp: 1'b1, ac: 1'b1, cy: 1'b1};
    unique case (op)
      OP_ADD: acc_wr_o = 1'b1;
      OP_ADC: begin acc_wr_o = 1'b1; ar_cin = carry_i; end
      OP_SUB: begin acc_wr_o = 1'b1; ar_sub = 1'b1; end
      OP_SBB: begin acc_wr_o = 1'b1; ar_sub = 1'b1; ar_cin = carry_i; end
      OP_CMP: ar_sub = 1'b1;
      OP_INC: begin
        ar_a = opnd_i; ar_b = '0; ar_cin = 1'b1;
        reg_wr_o = 1'b1; upd.cy = 1'b0;
      end
      OP_DEC: begin
        ar_a = opnd_i; ar_b = {{(DATA_W-1){1'b0}}, 1'b1}; ar_sub = 1'b1;
        reg_wr_o = 1'b1; upd.cy = 1'b0;
      end
      OP_AND, OP_XOR, OP_OR: begin use_arith = 1'b0; acc_wr_o = 1'b1; end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        use_arith = 1'b0; acc_wr_o = 1'b1;
        upd.szp = 1'b0; upd.ac = 1'b0;
      end
      default: begin use_arith = 1'b0; upd = '0; end
    endcase
  end

  alu8_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i   (ar_a),
    .b_i   (ar_b),
    .sub_i (ar_sub),
    .cin_i (ar_cin),
    .res_o (ar_res),
    .cy_o  (ar_cy),
    .ac_o  (ar_ac)
  );

  alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op_i  (op),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (carry_i),
    .res_o (bo_res),
    .cy_o  (bo_cy)
  );

  assign result_o = use_arith ? ar_res : bo_res;
  assign cy_sel   = use_arith ? ar_cy  : bo_cy;
  assign ac_sel   = use_arith ? ar_ac  : 1'b0;

  alu8_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .upd_i   (upd),
    .res_i   (result_o),
    .ac_i    (ac_sel),
    .cy_i    (cy_sel),
    .flags_o (flags_o)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              acc_wr_o,
  input logic              reg_wr_o,
  input logic [7:0]        flags_o
);
  logic szp_op, rot_op, incdec_op;
  assign szp_op    = (op_i <= 4'd9);
  assign rot_op    = (op_i >= 4'd10) && (op_i <= 4'd13);
  assign incdec_op = (op_i == 4'd8) || (op_i == 4'd9);

  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && szp_op |=> flags_o[3] == ($past(result_o) == '0));
  p_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && szp_op |=> flags_o[4] == $past(result_o[DATA_W-1]));
  p_parity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && szp_op |=> flags_o[1] == ~^$past(result_o));
  p_cmp_nowrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd7 |-> !acc_wr_o && !reg_wr_o);
  p_incdec_cy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && incdec_op |=> flags_o[0] == $past(flags_o[0]));
  p_rot_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && rot_op |=> flags_o[4:1] == $past(flags_o[4:1]));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flags_o));
  p_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_wr_o, reg_wr_o}));
  p_unused_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[7:5] == 3'b000);
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .op_i     (op_i),
  .result_o (result_o),
  .acc_wr_o (acc_wr_o),
  .reg_wr_o (reg_wr_o),
  .flags_o  (flags_o)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] acc = 8'd0, opnd = 8'd0;
  logic       cin = 1'b0;
  logic [7:0] result, flags;
  logic       acc_wr, reg_wr;

  int   checks = 0;
  int   fails  = 0;
  logic [7:0] exp_fl = 8'd0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .op_i(op), .acc_i(acc),
    .opnd_i(opnd), .carry_i(cin), .result_o(result), .acc_wr_o(acc_wr),
    .reg_wr_o(reg_wr), .flags_o(flags)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s op=%0d a=%02h b=%02h c=%0d actual=%0h expected=%0h",
               rq, what, op, acc, opnd, cin, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                                input logic c, input logic [7:0] fin,
                                output logic [7:0] res, output logic aw, output logic rw,
                                output logic [7:0] fout, output string rq);
    int s; logic cy, ac, szp, rot; int bw;
    res = a; aw = 0; rw = 0; cy = fin[0]; ac = fin[2]; szp = 0; rot = 0; rq = "R11";
    bw = (o == 4'd3) ? int'(c) : 0;
    case (o)
      4'd0, 4'd1: begin
        s = int'(a) + int'(b) + ((o == 4'd1) ? int'(c) : 0);
        res = s[7:0]; cy = (s > 255);
        ac = ((int'(a) & 15) + (int'(b) & 15) + ((o == 4'd1) ? int'(c) : 0)) > 15;
        aw = 1; szp = 1; rq = "R1";
      end
      4'd2, 4'd3, 4'd7: begin
        s = int'(a) - int'(b) - bw;
        res = s[7:0]; cy = (s < 0);
        ac = ((int'(a) & 15) - (int'(b) & 15) - bw) < 0;
        aw = (o != 4'd7); szp = 1; rq = (o == 4'd7) ? "R7" : "R2";
      end
      4'd4: begin res = a & b; cy = 0; ac = 0; aw = 1; szp = 1; rq = "R6"; end
      4'd5: begin res = a ^ b; cy = 0; ac = 0; aw = 1; szp = 1; rq = "R6"; end
      4'd6: begin res = a | b; cy = 0; ac = 0; aw = 1; szp = 1; rq = "R6"; end
      4'd8: begin res = b + 8'd1; ac = (b[3:0] == 4'hf); rw = 1; szp = 1; rq = "R8"; end
      4'd9: begin res = b - 8'd1; ac = (b[3:0] == 4'h0); rw = 1; szp = 1; rq = "R8"; end
      4'd10: begin res = {a[6:0], a[7]}; cy = a[7]; aw = 1; rot = 1; rq = "R9"; end
      4'd11: begin res = {a[0], a[7:1]}; cy = a[0]; aw = 1; rot = 1; rq = "R9"; end
      4'd12: begin res = {a[6:0], c};    cy = a[7]; aw = 1; rot = 1; rq = "R9"; end
      4'd13: begin res = {c, a[7:1]};    cy = a[0]; aw = 1; rot = 1; rq = "R9"; end
      default: ;
    endcase
    if (szp)      fout = {3'b000, res[7], res == 8'd0, ac, ~^res, cy};
    else if (rot) fout = {fin[7:1], cy};
    else          fout = fin;
  endfunction

  task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic c, input logic w);
    logic [7:0] er, ef; logic eaw, erw; string rq;
    @(negedge clk);
    op = o; acc = a; opnd = b; cin = c; we = w;
    model(o, a, b, c, exp_fl, er, eaw, erw, ef, rq);
    #1;
    if (o <= 4'd13) chk(rq, "result", result, er);
    chk((o == 4'd7 || o == 4'd8) ? rq : "R11", "acc_wr", acc_wr, eaw);
    chk((o == 4'd8 || o == 4'd9) ? "R8" : "R11", "reg_wr", reg_wr, erw);
    @(posedge clk);
    #1;
    if (w) exp_fl = ef;
    chk(w ? rq : "R10", "carry", flags[0], exp_fl[0]);
    chk(w ? "R3" : "R10", "aux", flags[2], exp_fl[2]);
    chk(w ? "R4" : "R10", "zero", flags[3], exp_fl[3]);
    chk(w ? "R4" : "R10", "sign", flags[4], exp_fl[4]);
    chk(w ? "R5" : "R10", "parity", flags[1], exp_fl[1]);
    chk("R11", "upper", flags[7:5], 0);
  endtask

  function automatic logic [7:0] grid(input int i);
    logic [7:0] corner [8] = '{8'h00, 8'h01, 8'h0f, 8'h10, 8'h7f, 8'h80, 8'hfe, 8'hff};
    return (i < 8) ? corner[i] : 8'((i - 8) * 17);
  endfunction

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset flags", flags, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // exhaustive combinational sweep of add/sub with carry-in
    for (int o = 1; o <= 3; o += 2) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          logic [7:0] er, ef; logic eaw, erw; string rq;
          op = 4'(o); acc = 8'(a); opnd = 8'(b); cin = 1'((a ^ b) >> 2);
          model(op, acc, opnd, cin, exp_fl, er, eaw, erw, ef, rq);
          #1;
          chk(rq, "sweep result", result, er);
        end
      end
    end

    // every opcode with flags over the boundary grid
    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 24; i++) begin
        for (int j = 0; j < 24; j += 3) begin
          run_op(4'(o), grid(i), grid(j), 1'((i + j + o) & 1), 1'b1);
        end
      end
    end

    // inc/dec and rotates keep their untouched flags from both carry states
    run_op(4'd0, 8'hff, 8'h01, 1'b0, 1'b1);  // R1 wrap: carry, aux, zero
    run_op(4'd8, 8'h00, 8'h7f, 1'b0, 1'b1);  // R8 carry stays 1
    run_op(4'd9, 8'h00, 8'h00, 1'b0, 1'b1);  // R8 borrow ignored
    run_op(4'd2, 8'h00, 8'h01, 1'b0, 1'b1);  // R2 borrow
    run_op(4'd12, 8'h01, 8'h00, 1'b1, 1'b1); // R9 through carry
    run_op(4'd13, 8'h80, 8'h00, 1'b0, 1'b1); // R9

    // R10: we low leaves flags untouched by any operation
    for (int o = 0; o < 14; o++) run_op(4'(o), 8'h55, 8'haa, 1'b1, 1'b0);
    // R11: unused opcodes with we high change nothing
    run_op(4'd14, 8'h00, 8'h00, 1'b1, 1'b1);
    run_op(4'd15, 8'hff, 8'hff, 1'b0, 1'b1);

    done = 1'b1;
    report();
  end
endmodule